// File: doc/BRIEF.md
# Transmit Holding Empty Status and Interrupt Timer

This block decides when a UART's transmitter reports that it can take more data, and when that report becomes an interrupt. It watches CPU writes into the transmit FIFO and the FIFO's occupancy. A pulse from the serializer marks the start of the final stop bit, and a periodic bit-time tick measures character time. From these it drives a holding-empty status bit and an interrupt request that is gated by its enable.

The empty status is held back when the FIFO only ever had one byte in it since the status was last raised. In that case the status waits about one character time less the stop bit after the FIFO drains, so software does not refill a FIFO whose last byte is still on the wire. If two or more bytes sat in the FIFO together since the last empty event, the status rises at once. Changing the FIFO-enable setting raises the interrupt at once when the status is set and the interrupt is enabled.

Top module: `thr_empty_ctrl`

## Requirements
- R1: After reset the empty status `thre_o` is 1 and `irq_o` is 0.
- R2: A CPU write (`wr_tx` high for a cycle) drives `thre_o` to 0 on the next cycle.
- R3: When `tx_count` is 0 while `thre_o` is 0, and occupancy reached 2 or more since `thre_o` last rose, `thre_o` rises on the next cycle.
- R4: Otherwise a wait starts on the following cycle, and `thre_o` rises in the cycle after the DELAY_TICKS-th `bit_tick` of that wait (default 9).
- R5: A `stop_start` pulse during that wait ends it, and `thre_o` rises on the next cycle.
- R6: Each rise of `thre_o` sets the request. `irq_o` is the request ANDed with `thre_ien`, so `irq_o` stays 0 while `thre_ien` is 0.
- R7: A change of `fifo_en` while `thre_o` is 1 and `thre_ien` is 1 sets `irq_o` on the next cycle.
- R8: `iid_rd` or `wr_tx` clears the request, and `irq_o` is 0 on the next cycle.
- R9: The record of two-byte occupancy is cleared when `thre_o` rises. A later single-byte burst is therefore delayed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_tx | input | 1 | CPU write into the transmit FIFO |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| stop_start | input | 1 | Serializer has begun the final stop bit |
| bit_tick | input | 1 | One pulse per bit time |
| fifo_en | input | 1 | FIFO-enable setting |
| thre_ien | input | 1 | Holding-empty interrupt enable |
| iid_rd | input | 1 | Interrupt identification read while this source is reported |
| thre_o | output | 1 | Holding-empty status |
| irq_o | output | 1 | Holding-empty interrupt request |

## Verification
The directed part feeds single-byte bursts and two-byte bursts. The first must wait out exactly DELAY_TICKS ticks and the second must not, so an off-by-one counter or a history flag that never clears shows up. A single-byte burst ended early by a stop-bit pulse separates the early-exit path from the tick count. A FIFO-enable toggle with the enable on and then off separates the immediate interrupt from its gating. A long seeded random run then mixes writes, drains, ticks, stop pulses, identification reads and enable changes against a bench model built from the requirements.

// File: rtl/thr_empty_pkg.sv
package thr_empty_pkg;
    typedef struct packed {
        logic thre;
        logic irq;
        logic seen_two;
        logic fen;
    } ctl_t;

    typedef struct packed {
        logic       busy;
        logic [7:0] cnt;
    } tmr_t;
endpackage

// File: rtl/thr_delay_timer.sv
module thr_delay_timer #(
    parameter int DELAY_TICKS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clear,
    input  logic tick,
    input  logic early,
    output logic done
);
    import thr_empty_pkg::*;
    localparam logic [7:0] LAST = 8'(DELAY_TICKS - 1);

    tmr_t st_d, st_q;

    always_comb begin
        done = st_q.busy && (early || (tick && st_q.cnt == LAST));
        st_d = st_q;
        if (clear || done) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (!st_q.busy && arm) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy && tick) begin
            st_d.cnt = st_q.cnt + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/thr_empty_ctrl.sv
module thr_empty_ctrl #(
    parameter int DEPTH       = 16,
    parameter int DELAY_TICKS = 9,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tx,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             stop_start,
    input  logic             bit_tick,
    input  logic             fifo_en,
    input  logic             thre_ien,
    input  logic             iid_rd,
    output logic             thre_o,
    output logic             irq_o
);
    import thr_empty_pkg::*;

    ctl_t c_d, c_q;
    logic empty_now, arm_slow, tmr_done, set_ev;

    assign empty_now = !c_q.thre && (tx_count == '0) && !wr_tx;
    assign arm_slow  = empty_now && !c_q.seen_two;

    thr_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm_slow),
        .clear (wr_tx || c_q.thre),
        .tick  (bit_tick),
        .early (stop_start),
        .done  (tmr_done)
    );

    always_comb begin
        c_d = c_q;
        c_d.fen = fifo_en;
        if (tx_count >= CNT_W'(2)) c_d.seen_two = 1'b1;
        set_ev = 1'b0;
        if (wr_tx) begin
            c_d.thre = 1'b0;
        end else if (empty_now && (c_q.seen_two || tmr_done)) begin
            c_d.thre = 1'b1;
            set_ev   = 1'b1;
        end
        if (set_ev) c_d.seen_two = 1'b0;
        if (wr_tx || iid_rd) begin
            c_d.irq = 1'b0;
        end else if (thre_ien && (set_ev || (c_q.thre && fifo_en != c_q.fen))) begin
            c_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{thre: 1'b1, irq: 1'b0, seen_two: 1'b0, fen: 1'b0};
        else        c_q <= c_d;
    end

    assign thre_o = c_q.thre;
    assign irq_o  = c_q.irq && thre_ien;
endmodule

// File: rtl/thr_empty_chk.sv
module thr_empty_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_tx,
    input logic [CNT_W-1:0] tx_count,
    input logic             fifo_en,
    input logic             thre_ien,
    input logic             iid_rd,
    input logic             thre_o,
    input logic             irq_o
);
    assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> !thre_o);
    assert_rise_needs_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thre_o) |-> ($past(tx_count) == '0 && !$past(wr_tx)));
    assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !thre_ien |-> !irq_o);
    assert_toggle_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_o && thre_ien && !wr_tx && !iid_rd && $changed(fifo_en)) |=> (irq_o || !thre_ien));
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd || wr_tx) |=> !irq_o);
endmodule

bind thr_empty_ctrl thr_empty_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .tx_count(tx_count),
    .fifo_en(fifo_en), .thre_ien(thre_ien), .iid_rd(iid_rd),
    .thre_o(thre_o), .irq_o(irq_o)
);

// File: tb/thr_empty_ctrl_test.sv
module thr_empty_ctrl_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int LIM    = 9;
    localparam int CW     = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0;
    logic wr_tx = 0, pop = 0, stop_start = 0, bit_tick = 0;
    logic fifo_en = 0, thre_ien = 1, iid_rd = 0;
    logic [CW-1:0] cnt = '0;
    logic thre_o, irq_o;
    int total = 0, bad = 0;

    // reference model state
    logic m_thre = 1, m_req = 0, m_two = 0, m_fen = 0, m_wait = 0;
    int   m_ticks = 0;

    thr_empty_ctrl #(.DEPTH(DEPTH), .DELAY_TICKS(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .tx_count(cnt),
        .stop_start(stop_start), .bit_tick(bit_tick), .fifo_en(fifo_en),
        .thre_ien(thre_ien), .iid_rd(iid_rd), .thre_o(thre_o), .irq_o(irq_o));

    always #(PERIOD/2) clk = ~clk;

    function automatic logic exp_irq(logic req, logic en);
        return req & en;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            logic empt, rise;
            empt = !m_thre && cnt == 0 && !wr_tx;
            rise = empt && (m_two || (m_wait && (stop_start || (bit_tick && m_ticks == LIM-1))));
            if (wr_tx || m_thre || (m_wait && rise)) begin m_wait <= 0; m_ticks <= 0; end
            else if (!m_wait && empt && !m_two) begin m_wait <= 1; m_ticks <= 0; end
            else if (m_wait && bit_tick) m_ticks <= m_ticks + 1;
            if (wr_tx) m_thre <= 0; else if (rise) m_thre <= 1;
            if (rise) m_two <= 0; else if (cnt >= 2) m_two <= 1;
            if (wr_tx || iid_rd) m_req <= 0;
            else if (thre_ien && (rise || (m_thre && fifo_en != m_fen))) m_req <= 1;
            m_fen <= fifo_en;
            cnt <= cnt + CW'(wr_tx) - CW'(pop);
        end
    end

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic w, logic p, logic t, logic s, logic r);
        wr_tx = w; pop = p; bit_tick = t; stop_start = s; iid_rd = r;
        @(negedge clk);
        wr_tx = 0; pop = 0; bit_tick = 0; stop_start = 0; iid_rd = 0;
    endtask

    initial begin
        #(PERIOD*100000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk); @(negedge clk);
        check("R1 thre", thre_o, 1'b1);
        check("R1 irq", irq_o, 1'b0);
        rst_n = 1;
        @(negedge clk);
        // R2 and R4: single byte waits LIM ticks
        step(1,0,0,0,0); check("R2 thre after write", thre_o, 1'b0);
        step(0,1,0,0,0);
        step(0,0,0,0,0);
        for (int i = 0; i < LIM-1; i++) step(0,0,1,0,0);
        check("R4 still waiting", thre_o, 1'b0);
        step(0,0,1,0,0);
        check("R4 thre after ticks", thre_o, 1'b1);
        check("R6 irq on rise", irq_o, 1'b1);
        step(0,0,0,0,1); check("R8 read clears", irq_o, 1'b0);
        // R5 early end
        step(1,0,0,0,0); step(0,1,0,0,0); step(0,0,0,0,0);
        step(0,0,1,0,0);
        step(0,0,0,1,0); check("R5 stop ends wait", thre_o, 1'b1);
        // R3 two bytes: immediate
        step(1,0,0,0,0); step(1,0,0,0,0); check("R8 write clears", irq_o, 1'b0);
        step(0,1,0,0,0); step(0,1,0,0,0);
        step(0,0,0,0,0); check("R3 immediate", thre_o, 1'b1);
        // R9 history cleared
        step(1,0,0,0,0); step(0,1,0,0,0); step(0,0,0,0,0); step(0,0,0,0,0);
        check("R9 delayed again", thre_o, 1'b0);
        step(0,0,0,1,0); check("R9 done", thre_o, 1'b1);
        step(0,0,0,0,1);
        // R7 fifo_en toggle
        fifo_en = 1; @(negedge clk);
        check("R7 toggle irq", irq_o, 1'b1);
        step(0,0,0,0,1);
        thre_ien = 0; fifo_en = 0; @(negedge clk);
        check("R6 gated", irq_o, 1'b0);
        thre_ien = 1; step(0,0,0,0,1);
        // random phase against model
        for (int n = 0; n < 20000; n++) begin
            logic w, p;
            w = ($urandom % 5 == 0) && cnt < DEPTH;
            p = ($urandom % 4 == 0) && cnt > 0;
            if ($urandom % 300 == 0) fifo_en = ~fifo_en;
            if ($urandom % 200 == 0) thre_ien = ~thre_ien;
            step(w, p, $urandom % 3 == 0, $urandom % 25 == 0, $urandom % 10 == 0);
            check("R4 model thre", thre_o, m_thre);
            check("R6 model irq", irq_o, exp_irq(m_req, thre_ien));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule